// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is one bank of general-purpose pins behind a small word-addressed register bus. For each pin, software sets a direction bit and an output bit. It reads back the pin's input level after that level has passed through a two-stage synchronizer.

Each pin can also flag an event. Software picks the trigger per pin:

- with the both-edges bit set, any transition raises an event;
- with the both-edges bit clear, a polarity bit chooses between rising only and falling only.

Events latch into a sticky pending register, which software clears by writing ones. A mask register chooses which pending bits reach the single registered interrupt line. A status view shows the raw event condition of the current cycle.

Reads are combinational from the address. A write takes effect at the clock edge where `bus_wr` is high. Word offsets, all 32 bits wide with bit i belonging to pin i:

| Offset | Register | Access |
|---|---|---|
| 0x00 | direction | read/write |
| 0x04 | input level | read-only |
| 0x08 | output value | read/write |
| 0x0C | both-edges select | read/write |
| 0x10 | polarity | read/write |
| 0x14 | event status | read-only |
| 0x18 | pending | write-one-to-clear |
| 0x1C | interrupt mask | read/write |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: The direction word at 0x00 drives `pin_oe` (1 = output, 0 = input). The output word at 0x08 drives `pin_out`. Both read back as written.
- R3: Offset 0x04 returns the level of `pin_in` (1 = high) two clock edges after it changes. After only one edge it still shows the old level.
- R4: With both-edges bit 0 and polarity bit 0, a 0→1 transition sets that pin's pending bit (0x18) three edges after the change. A 1→0 transition sets nothing.
- R5: With both-edges bit 0 and polarity bit 1 (0x10), only a 1→0 transition sets the pending bit.
- R6: With the both-edges bit 1 (0x0C), both transition directions set the pending bit, whatever the polarity bit holds.
- R7: Writing a 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: Pending bits latch whether or not their mask bit (0x1C) is set. `irq` is the OR of pending AND mask, registered one edge later.
- R9: Offset 0x14 shows, for the current cycle only, which pins meet their event condition. Writes to it are ignored.
- R10: If an event and a clear of the same pending bit fall on the same edge, the bit stays set.
- R11: Reads of an unaligned offset or an offset at or above 0x20 return 0. Writes there, and to offset 0x04, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (6) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | PINS (32) | Asynchronous pin levels |
| pin_out | output | PINS (32) | Output value per pin |
| pin_oe | output | PINS (32) | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Edge detection is exercised by raising and then lowering a single pin under each of the three trigger settings. The pending word after each transition tells whether the trigger responds to the correct direction only.

A multi-bit input pattern, sampled one and two edges after it changes, separates correct synchronizer latency from a path that is too short. Clears are tried in three forms:

- with no event present, to confirm a plain clear works;
- with a zero write, to confirm zeros have no effect;
- on the exact edge of a fresh event, to confirm the event wins.

Mask patterns that first miss and then cover the pending bit show that the interrupt is gated by the mask while the pending bit itself is not. Unaligned and out-of-range addresses are checked for aliasing onto real registers.

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port #(
  parameter int PINS = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  localparam int NREG = 8;
  localparam int WIX  = AW - 2;
  localparam logic [WIX-1:0] IX_DIR  = WIX'(0);
  localparam logic [WIX-1:0] IX_LVL  = WIX'(1);
  localparam logic [WIX-1:0] IX_DRV  = WIX'(2);
  localparam logic [WIX-1:0] IX_BOTH = WIX'(3);
  localparam logic [WIX-1:0] IX_POL  = WIX'(4);
  localparam logic [WIX-1:0] IX_STAT = WIX'(5);
  localparam logic [WIX-1:0] IX_PEND = WIX'(6);
  localparam logic [WIX-1:0] IX_MASK = WIX'(7);

  logic [WIX-1:0]  widx;
  logic            hit;
  logic [NREG-1:0] we;
  logic [PINS-1:0] wdat;
  logic [PINS-1:0] dir_q, drv_q, both_q, pol_q, mask_q, pend_q;
  logic [PINS-1:0] s1_q, s2_q, prev_q;
  logic [PINS-1:0] rise, fall, evt;
  logic            irq_q;

  assign widx = bus_addr[AW-1:2];
  assign hit  = (bus_addr[1:0] == 2'b00) && (widx < WIX'(NREG));
  assign wdat = bus_wdata[PINS-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_we
    assign we[k] = bus_wr && hit && (widx == WIX'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
  assign evt  = (both_q & (rise | fall))
              | (~both_q & ~pol_q & rise)
              | (~both_q & pol_q & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      drv_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      if (we[IX_DIR])  dir_q  <= wdat;
      if (we[IX_DRV])  drv_q  <= wdat;
      if (we[IX_BOTH]) both_q <= wdat;
      if (we[IX_POL])  pol_q  <= wdat;
      if (we[IX_MASK]) mask_q <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(we[IX_PEND] ? wdat : '0)) | evt;
      irq_q  <= |(pend_q & mask_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (widx)
        IX_DIR:  bus_rdata[PINS-1:0] = dir_q;
        IX_LVL:  bus_rdata[PINS-1:0] = s2_q;
        IX_DRV:  bus_rdata[PINS-1:0] = drv_q;
        IX_BOTH: bus_rdata[PINS-1:0] = both_q;
        IX_POL:  bus_rdata[PINS-1:0] = pol_q;
        IX_STAT: bus_rdata[PINS-1:0] = evt;
        IX_PEND: bus_rdata[PINS-1:0] = pend_q;
        IX_MASK: bus_rdata[PINS-1:0] = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = drv_q;
  assign irq     = irq_q;
endmodule

module gpio_edge_port_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pend,
  input logic [PINS-1:0] mask,
  input logic [PINS-1:0] evt,
  input logic [PINS-1:0] s2,
  input logic [PINS-1:0] prev,
  input logic            we_pend
);
  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (irq == 1'b0 && pin_oe == '0); // R1

  AST_EVT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(s2 ^ prev)) == '0); // R9

  AST_PEND_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(evt)) == '0); // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_pend |=> ((pend & $past(pend)) == $past(pend))); // R7

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask & pend) == '0) |-> !irq); // R8

  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pend && evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R10
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pin_oe(pin_oe), .pend(pend_q),
  .mask(mask_q), .evt(evt), .s2(s2_q), .prev(prev_q), .we_pend(we[IX_PEND])
);

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pout, poe;
  logic        irq;
  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] e);
    logic [31:0] d;
    rreg(a, d);
    chk(req, d, e);
  endtask

  task automatic clear_all();
    wreg(6'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) expect_reg("R1", 6'(k * 4), 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 oe", poe, 32'h0);
    chk("R1 out", pout, 32'h0);
  endtask

  task automatic t_dir();
    wreg(6'h00, 32'hA5A5_0F0F);
    wreg(6'h08, 32'h1234_5678);
    chk("R2 oe", poe, 32'hA5A5_0F0F);
    chk("R2 out", pout, 32'h1234_5678);
    expect_reg("R2", 6'h00, 32'hA5A5_0F0F);
    expect_reg("R2", 6'h08, 32'h1234_5678);
    wreg(6'h00, 32'h0);
  endtask

  task automatic t_input();
    pins = 32'hCAFE_0001;
    step(1);
    expect_reg("R3 early", 6'h04, 32'h0);
    step(1);
    expect_reg("R3", 6'h04, 32'hCAFE_0001);
    pins = 32'h0;
    step(4);
    clear_all();
    expect_reg("R7 all", 6'h18, 32'h0);
  endtask

  task automatic t_rise();
    pins[3] = 1'b1; step(3);
    expect_reg("R4 rise", 6'h18, 32'h8);
    clear_all();
    pins[3] = 1'b0; step(3);
    expect_reg("R4 fall", 6'h18, 32'h0);
  endtask

  task automatic t_fall();
    wreg(6'h10, 32'h20);
    pins[5] = 1'b1; step(3);
    expect_reg("R5 rise", 6'h18, 32'h0);
    pins[5] = 1'b0; step(3);
    expect_reg("R5 fall", 6'h18, 32'h20);
    clear_all();
  endtask

  task automatic t_both();
    wreg(6'h0C, 32'h80);
    wreg(6'h10, 32'h80);
    pins[7] = 1'b1; step(3);
    expect_reg("R6 rise", 6'h18, 32'h80);
    clear_all();
    pins[7] = 1'b0; step(3);
    expect_reg("R6 fall", 6'h18, 32'h80);
    clear_all();
  endtask

  task automatic t_w1c();
    pins[3] = 1'b1; pins[7] = 1'b1; step(3);
    expect_reg("R7 set", 6'h18, 32'h88);
    wreg(6'h18, 32'h0);
    expect_reg("R7 zero", 6'h18, 32'h88);
    wreg(6'h18, 32'h8);
    expect_reg("R7 one", 6'h18, 32'h80);
  endtask

  task automatic t_irq();
    step(1);
    chk("R8 masked", {31'b0, irq}, 32'h0);
    expect_reg("R8 latched", 6'h18, 32'h80);
    wreg(6'h1C, 32'h80); step(1);
    chk("R8 on", {31'b0, irq}, 32'h1);
    wreg(6'h1C, 32'h08); step(1);
    chk("R8 other", {31'b0, irq}, 32'h0);
    wreg(6'h1C, 32'h80); step(1);
    chk("R8 again", {31'b0, irq}, 32'h1);
    wreg(6'h18, 32'h80); step(1);
    chk("R8 cleared", {31'b0, irq}, 32'h0);
    wreg(6'h1C, 32'h0);
  endtask

  task automatic t_status();
    pins[9] = 1'b1; step(2);
    expect_reg("R9 live", 6'h14, 32'h200);
    step(1);
    expect_reg("R9 gone", 6'h14, 32'h0);
    wreg(6'h14, 32'hFFFF_FFFF);
    expect_reg("R9 wr", 6'h14, 32'h0);
    wreg(6'h04, 32'h0);
    expect_reg("R11 lvl", 6'h04, pins);
    clear_all();
  endtask

  task automatic t_collide();
    pins[7] = 1'b0; step(3);
    expect_reg("R10 pre", 6'h18, 32'h80);
    pins[7] = 1'b1; step(2);
    wreg(6'h18, 32'h80);
    expect_reg("R10 held", 6'h18, 32'h80);
    wreg(6'h18, 32'h80);
    expect_reg("R10 quiet", 6'h18, 32'h0);
  endtask

  task automatic t_unmapped();
    wreg(6'h00, 32'h0000_FFFF);
    wreg(6'h20, 32'hFFFF_FFFF);
    wreg(6'h01, 32'hFFFF_FFFF);
    expect_reg("R11 alias", 6'h00, 32'h0000_FFFF);
    expect_reg("R11 hi", 6'h20, 32'h0);
    expect_reg("R11 top", 6'h3C, 32'h0);
    expect_reg("R11 odd", 6'h02, 32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_dir();
    t_input();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_irq();
    t_status();
    t_collide();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule